// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block selects, for each of six counter channels, the signal that clocks the channel and the signal that gates it. The channels are arranged as two counter chips per group with three channels on each chip. Software writes selections through a byte-wide register port. A write to a group's clock-select address or gate-select address carries a chip bit, a channel field and a 5-bit source code. The block stores that code for the addressed channel and from then on drives the chosen source onto the channel's clock-enable or gate output.

One fast reference clock runs the block. A prescaler followed by a chain of decade dividers produces internal time bases as single-cycle enable strobes. The channel's own clock and gate pins are muxed in next to these strobes. A mode input sets the legal code range. In basic mode only codes 0 to 7 are accepted. In enhanced mode all 32 codes are accepted, including a fast time base at code 11. Codes that are illegal in the current mode, or that have no source assigned, drive a constant 0.

Top module: `clk_gate_router`

## Requirements
- R1: After reset every channel uses clock code 0 and gate code 0. All `ctr_gate` bits are 1 and `ctr_clk_en` equals `ext_clk`.
- R2: A write to address 0x18+g stores a clock code. In the data byte, bit 5 is the chip, bits 4:3 are the channel (0 to 2), bits 2:0 are code bits 2:0 and bits 7:6 are code bits 4:3. The addressed channel is index 6g + 3·chip + channel. The new code acts from the cycle after the write edge.
- R3: A write to address 0x1B+g stores a gate code in the same byte layout. Gate code 0 drives 1. Gate code 1 drives that channel's `ext_gate` pin.
- R4: Clock codes 1 to 5 give a strobe every 2·PRE_DIV·10^(k−1) reference cycles for code k. With a 20·PRE_DIV MHz reference these periods are 100 ns, 1 µs, 10 µs, 100 µs and 1 ms.
- R5: In enhanced mode (`enh_mode`=1), clock code 11 gives a strobe every PRE_DIV cycles, which is 20 MHz.
- R6: In basic mode, a stored code whose bits 4:3 are not zero drives 0. This applies to both the clock output and the gate output.
- R7: Reserved codes drive 0. For clocks these are 6 to 10 and 12 to 31. For gates they are 2 to 31.
- R8: Some writes change no stored code. These are writes whose channel field is 3, writes to any other address, and writes to a group beyond NUM_GROUPS. A write to one channel leaves every other channel's selection unchanged.
- R9: Every internal time-base strobe is high for a single cycle and is never high in two consecutive cycles.
- R10: With clock code 0, `ctr_clk_en` of that channel follows its `ext_clk` pin in the same cycle, without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enh_mode | input | 1 | 1 = enhanced code range 0..31, 0 = basic range 0..7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register offset |
| wr_data | input | 8 | Select byte |
| ext_clk | input | 6·NUM_GROUPS | Dedicated per-channel clock pins, as enables synchronous to clk |
| ext_gate | input | 6·NUM_GROUPS | Per-channel gate pins, synchronous to clk |
| ctr_clk_en | output | 6·NUM_GROUPS | Selected clock enable per channel |
| ctr_gate | output | 6·NUM_GROUPS | Selected gate level per channel |

## Verification
The assertions rely on a few assumptions about the inputs. The pins `ext_clk`, `ext_gate` and `enh_mode`, and the write port, must be synchronous to the reference clock. PRE_DIV must be at least 2, which is what makes the single-cycle strobe property (R9) hold. The bench drives every input half a period away from the sampling edge and leaves the mode input constant while it measures any one period. It measures strobe periods from one strobe to the next, so the results do not depend on the phase of the divider chain. It also checks that writes which should be ignored leave all outputs unchanged.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int SRC_W = 5;
  localparam int DECADES = 5;
  localparam int CHIPS_PER_GROUP = 2;
  localparam int CH_PER_CHIP = 3;

  typedef logic [SRC_W-1:0] src_t;

  localparam src_t CLK_SRC_PIN   = 5'd0;
  localparam src_t CLK_SRC_FAST  = 5'd11;
  localparam src_t GATE_SRC_HIGH = 5'd0;
  localparam src_t GATE_SRC_PIN  = 5'd1;

  localparam logic [7:0] CLK_SEL_BASE  = 8'h18;
  localparam logic [7:0] GATE_SEL_BASE = 8'h1B;

  // high code bits sit in [7:6], low code bits in [2:0]
  function automatic src_t unpack_src(input logic [7:0] b);
    return {b[7:6], b[2:0]};
  endfunction
endpackage

// File: rtl/cgr_strobe_div.sv
module cgr_strobe_div #(
  parameter int RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stb,
  output logic out_stb
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = 1'b0;
    if (in_stb) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_stb <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      out_stb <= out_d;
    end
  end
endmodule

// File: rtl/cgr_tick_gen.sv
module cgr_tick_gen #(
  parameter int PRE_DIV = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [cgr_pkg::DECADES:0] tick
);
  // tick[0]: fast base, one per PRE_DIV cycles
  // tick[1]: half of fast base; tick[k>1]: tick[k-1] / 10
  for (genvar k = 0; k <= cgr_pkg::DECADES; k++) begin : g_stage
    if (k == 0) begin : g_pre
      cgr_strobe_div #(.RATIO(PRE_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_stb (1'b1),
        .out_stb(tick[0])
      );
    end else begin : g_dec
      cgr_strobe_div #(.RATIO((k == 1) ? 2 : 10)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_stb (tick[k-1]),
        .out_stb(tick[k])
      );
    end
  end
endmodule

// File: rtl/cgr_chan_route.sv
module cgr_chan_route
  import cgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_mode,
  input  logic             wr_clk,
  input  logic             wr_gate,
  input  src_t             wr_src,
  input  logic             ext_clk,
  input  logic             ext_gate,
  input  logic [DECADES:0] tick,
  output logic             clk_en,
  output logic             gate,
  output src_t             clk_code,
  output src_t             gate_code
);
  src_t clk_code_d, gate_code_d;
  logic clk_legal, gate_legal;

  always_comb begin
    clk_code_d  = wr_clk  ? wr_src : clk_code;
    gate_code_d = wr_gate ? wr_src : gate_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_code  <= CLK_SRC_PIN;
      gate_code <= GATE_SRC_HIGH;
    end else begin
      clk_code  <= clk_code_d;
      gate_code <= gate_code_d;
    end
  end

  assign clk_legal  = enh_mode || (clk_code[SRC_W-1:3] == '0);
  assign gate_legal = enh_mode || (gate_code[SRC_W-1:3] == '0);

  always_comb begin
    clk_en = 1'b0;
    if (clk_legal) begin
      if (clk_code == CLK_SRC_PIN) clk_en = ext_clk;
      if (clk_code == CLK_SRC_FAST) clk_en = tick[0];
      for (int k = 1; k <= DECADES; k++) begin
        if (clk_code == src_t'(k)) clk_en = tick[k];
      end
    end
  end

  always_comb begin
    gate = 1'b0;
    if (gate_legal) begin
      if (gate_code == GATE_SRC_HIGH) gate = 1'b1;
      else if (gate_code == GATE_SRC_PIN) gate = ext_gate;
    end
  end
endmodule

// File: rtl/clk_gate_router.sv
module clk_gate_router
  import cgr_pkg::*;
#(
  parameter int NUM_GROUPS = 1,
  parameter int PRE_DIV    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enh_mode,
  input  logic                           wr_en,
  input  logic [7:0]                     wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic [NUM_GROUPS*CHIPS_PER_GROUP*CH_PER_CHIP-1:0] ext_clk,
  input  logic [NUM_GROUPS*CHIPS_PER_GROUP*CH_PER_CHIP-1:0] ext_gate,
  output logic [NUM_GROUPS*CHIPS_PER_GROUP*CH_PER_CHIP-1:0] ctr_clk_en,
  output logic [NUM_GROUPS*CHIPS_PER_GROUP*CH_PER_CHIP-1:0] ctr_gate
);
  localparam int CH_PER_GRP = CHIPS_PER_GROUP * CH_PER_CHIP;
  localparam int NCH        = NUM_GROUPS * CH_PER_GRP;
  localparam int NTICK      = DECADES + 1;

  logic [1:0]                rst_pipe;
  logic                      rst_q;
  logic [NTICK-1:0]          tick;
  src_t                      wr_src;
  logic [NCH-1:0][SRC_W-1:0] clk_code_w;
  logic [NCH-1:0][SRC_W-1:0] gate_code_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign wr_src = unpack_src(wr_data);

  cgr_tick_gen #(.PRE_DIV(PRE_DIV)) u_ticks (
    .clk  (clk),
    .rst_n(rst_q),
    .tick (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP  = i / CH_PER_GRP;
    localparam int CHIP = (i % CH_PER_GRP) / CH_PER_CHIP;
    localparam int CHN  = i % CH_PER_CHIP;

    logic sel_match, wr_clk_s, wr_gate_s;

    assign sel_match = (wr_data[5] == 1'(CHIP)) && (wr_data[4:3] == 2'(CHN));
    assign wr_clk_s  = wr_en && sel_match && (wr_addr == CLK_SEL_BASE + 8'(GRP));
    assign wr_gate_s = wr_en && sel_match && (wr_addr == GATE_SEL_BASE + 8'(GRP));

    cgr_chan_route u_route (
      .clk      (clk),
      .rst_n    (rst_q),
      .enh_mode (enh_mode),
      .wr_clk   (wr_clk_s),
      .wr_gate  (wr_gate_s),
      .wr_src   (wr_src),
      .ext_clk  (ext_clk[i]),
      .ext_gate (ext_gate[i]),
      .tick     (tick),
      .clk_en   (ctr_clk_en[i]),
      .gate     (ctr_gate[i]),
      .clk_code (clk_code_w[i]),
      .gate_code(gate_code_w[i])
    );
  end
endmodule

// File: rtl/cgr_router_chk.sv
module cgr_router_chk #(
  parameter int NCH   = 6,
  parameter int NTICK = 6
) (
  input logic                  clk,
  input logic                  rst_q,
  input logic                  enh_mode,
  input logic                  wr_en,
  input logic [7:0]            wr_data,
  input logic [NCH-1:0]        ext_clk,
  input logic [NCH-1:0]        ext_gate,
  input logic [NCH-1:0]        ctr_clk_en,
  input logic [NCH-1:0]        ctr_gate,
  input logic [NCH-1:0][4:0]   clk_code,
  input logic [NCH-1:0][4:0]   gate_code,
  input logic [NTICK-1:0]      tick
);
  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_data[4:3] == 2'b11) |=> ($stable(clk_code) && $stable(gate_code)));

  for (genvar k = 0; k < NTICK; k++) begin : g_tk
    // R9
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_q)
      tick[k] |=> !tick[k]);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R10
    pin_clock_pass_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (clk_code[i] == 5'd0) |-> (ctr_clk_en[i] == ext_clk[i]));
    // R3
    gate_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (gate_code[i] == 5'd0) |-> ctr_gate[i]);
    // R3
    gate_pin_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (gate_code[i] == 5'd1) |-> (ctr_gate[i] == ext_gate[i]));
    // R6
    basic_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (!enh_mode && clk_code[i][4:3] != 2'b00) |-> !ctr_clk_en[i]);
    // R7
    gate_reserved_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (gate_code[i] > 5'd1) |-> !ctr_gate[i]);
    // R7
    clk_reserved_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (clk_code[i] > 5'd5 && clk_code[i] != 5'd11) |-> !ctr_clk_en[i]);
  end
endmodule

bind clk_gate_router cgr_router_chk #(.NCH(NCH), .NTICK(NTICK)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .enh_mode  (enh_mode),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ext_clk   (ext_clk),
  .ext_gate  (ext_gate),
  .ctr_clk_en(ctr_clk_en),
  .ctr_gate  (ctr_gate),
  .clk_code  (clk_code_w),
  .gate_code (gate_code_w),
  .tick      (tick)
);

// File: tb/clk_gate_router_test.sv
`timescale 1ns/1ps
module clk_gate_router_test;
  localparam int PRE_DIV = 2;
  localparam int NCH = 6;
  localparam int K_GATEVEC = 0, K_CLKVEC = 1, K_CLK1 = 2, K_PERIOD = 3, K_SILENT = 4;

  typedef struct {
    int    kind;
    int    ch;
    int    exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, enh_mode, wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [NCH-1:0] ext_clk, ext_gate, ctr_clk_en, ctr_gate;

  item_t sb[$];
  bit busy = 1'b0;
  bit done = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  clk_gate_router #(.NUM_GROUPS(1), .PRE_DIV(PRE_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_clk(ext_clk), .ext_gate(ext_gate),
    .ctr_clk_en(ctr_clk_en), .ctr_gate(ctr_gate)
  );

  function automatic int period_of(input int code);
    int p;
    if (code == 11) return PRE_DIV;
    p = 2 * PRE_DIV;
    for (int k = 1; k < code; k++) p = p * 10;
    return p;
  endfunction

  task automatic report(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input int kind, input int ch, input int exp, input string req);
    item_t it;
    it.kind = kind; it.ch = ch; it.exp = exp; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0 && !busy);
  endtask

  // monitor: pops one expectation and measures it at the ports
  initial begin
    forever begin
      item_t it;
      int act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      busy = 1'b1;
      #2;
      act = 0;
      case (it.kind)
        K_GATEVEC: act = int'(ctr_gate);
        K_CLKVEC:  act = int'(ctr_clk_en);
        K_CLK1:    act = int'(ctr_clk_en[it.ch]);
        K_PERIOD: begin
          int w = 0;
          while (!ctr_clk_en[it.ch] && w < 100000) begin @(negedge clk); w++; end
          do begin @(negedge clk); act++; end while (!ctr_clk_en[it.ch] && act < 100000);
        end
        default: begin
          for (int c = 0; c < it.exp; c++) begin
            @(negedge clk);
            if (ctr_clk_en[it.ch]) act++;
          end
          it.exp = 0;
        end
      endcase
      report(it.req, act, it.exp);
      busy = 1'b0;
    end
  end

  initial begin
    #(20 * 180000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enh_mode = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ext_clk = '0; ext_gate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_item(K_GATEVEC, 0, 'h3F, "R1 gates high after reset");
    ext_clk = 6'b100101;
    expect_item(K_CLKVEC, 0, 'h25, "R1 clocks follow pins after reset");
    ext_clk = 6'b011010;
    expect_item(K_CLKVEC, 0, 'h1A, "R10 pin clock same cycle");
    ext_clk = '0;

    // R2 / R4 byte layout and decade periods
    write_reg(8'h18, 8'h01);
    expect_item(K_PERIOD, 0, period_of(1), "R4 code1 chip0 ch0");
    write_reg(8'h18, 8'h32);
    expect_item(K_PERIOD, 5, period_of(2), "R2 chip1 ch2 code2");
    expect_item(K_PERIOD, 0, period_of(1), "R8 other channel kept");
    write_reg(8'h18, 8'h0B);
    expect_item(K_PERIOD, 1, period_of(3), "R2 chip0 ch1 code3");

    // R3 gate selection
    write_reg(8'h1B, 8'h09);
    expect_item(K_GATEVEC, 0, 'h3D, "R3 gate pin low");
    ext_gate = 6'b000010;
    expect_item(K_GATEVEC, 0, 'h3F, "R3 gate pin high");
    write_reg(8'h1B, 8'h0A);
    expect_item(K_GATEVEC, 0, 'h3D, "R7 gate code2 reserved");
    write_reg(8'h1B, 8'h08);
    expect_item(K_GATEVEC, 0, 'h3F, "R3 gate code0 high");

    // R8 ignored writes
    write_reg(8'h1B, 8'h1A);
    expect_item(K_GATEVEC, 0, 'h3F, "R8 channel field 3");
    write_reg(8'h1E, 8'h02);
    expect_item(K_GATEVEC, 0, 'h3F, "R8 undecoded address");
    write_reg(8'h1C, 8'h02);
    expect_item(K_GATEVEC, 0, 'h3F, "R8 absent group");

    // R5 / R9 fast base, R6 basic mask, R7 reserved
    enh_mode = 1'b1;
    write_reg(8'h18, 8'h6B);
    expect_item(K_PERIOD, 4, period_of(11), "R5 code11 enhanced, R9 single cycle");
    enh_mode = 1'b0;
    expect_item(K_SILENT, 4, 200, "R6 code11 in basic mode");
    write_reg(8'h18, 8'h69);
    expect_item(K_SILENT, 4, 200, "R6 code9 not aliased in basic mode");
    enh_mode = 1'b1;
    expect_item(K_SILENT, 4, 200, "R7 code9 reserved");
    enh_mode = 1'b0;
    write_reg(8'h18, 8'h06);
    expect_item(K_SILENT, 0, 200, "R7 clock code6 reserved");

    // R10 back to pin
    write_reg(8'h18, 8'h00);
    ext_clk = 6'b000001;
    expect_item(K_CLK1, 0, 1, "R10 pin high");
    ext_clk = '0;
    expect_item(K_CLK1, 0, 0, "R10 pin low");

    // R4 slow decades
    write_reg(8'h18, 8'h14);
    expect_item(K_PERIOD, 2, period_of(4), "R4 code4");
    write_reg(8'h18, 8'h25);
    expect_item(K_PERIOD, 3, period_of(5), "R4 code5");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule